// File: doc/BRIEF.md
# Lane-Striped Vector Execution Unit

This block executes one vector arithmetic instruction at a time. Each instruction names an operation, two source vector registers, a destination vector register and a run-time element count. The unit has `LANES` identical lanes that move together. Element `i` of every vector register is held by lane `i % LANES`, in slot `i / LANES` of that lane's register-file slice. Each busy cycle the unit reads one group of `LANES` element pairs and writes one group of `LANES` results. Groups are processed in ascending slot order.

The register-file slices are outside this block. Their read ports return data in the same cycle as the address. Every lane sees the same slot address, so the address outputs are shared by all lanes. The data buses and write enables are per lane, packed as lane `l` at bits `[l*ELEM_W +: ELEM_W]`. A slice address is `{register index, slot}`, with the slot in the low `SLOT_W` bits.

Once an instruction is accepted, it holds the unit until its last group has been written. A one-cycle completion pulse then marks the end.

Top module: `vec_lane_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0, every `rfWrEn` bit is 0 and `issueReady` is 1. While idle, no write enable is asserted.
- R2: An instruction is accepted on a rising clock edge where both `issueValid` and `issueReady` are 1. `issueReady` equals the inverse of `busy`.
- R3: Element `i` of register `r` is read and written in lane `i % LANES` at slice address `{r, i / LANES}`.
- R4: The operation encodings of `issueOp` are: 0 = A+B, 1 = A−B, 2 = A AND B, 3 = A OR B, 4 = A XOR B. All are computed on `ELEM_W` bits and wrap modulo 2^ELEM_W. A is the element of `issueSrcA` and B is the element of `issueSrcB`.
- R5: The cycle after acceptance works on slot 0, and each following busy cycle works on the next slot.
- R6: In the final group, lanes whose element index is at or above the element count do not assert their write enable. The enabled lanes always form a contiguous run starting at lane 0.
- R7: An element count above `MAX_VL` is treated as `MAX_VL`. An element count of 0 keeps the unit busy for one cycle and writes nothing.
- R8: From acceptance until its last group, `busy` stays 1. `issueValid` raised during that time is not accepted and changes no register.
- R9: With n = max(1, ceil(count / LANES)) groups, the last write happens at the n-th rising edge after acceptance. In the cycle after that edge, `busy` is 0 and `done` is 1 for exactly one cycle.
- R10: Opcodes 5, 6 and 7 write no element, but the unit still runs for the normal number of cycles and completes as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction offered |
| issueReady | output | 1 | Unit can accept an instruction |
| issueOp | input | 3 | Operation code |
| issueSrcA | input | REG_W | First source register |
| issueSrcB | input | REG_W | Second source register |
| issueDst | input | REG_W | Destination register |
| issueLen | input | VL_W | Element count |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rfRdAddrA | output | ADDR_W | Slice read address, first operand (all lanes) |
| rfRdDataA | input | LANES*ELEM_W | First operand data, one word per lane |
| rfRdAddrB | output | ADDR_W | Slice read address, second operand (all lanes) |
| rfRdDataB | input | LANES*ELEM_W | Second operand data, one word per lane |
| rfWrAddr | output | ADDR_W | Slice write address (all lanes) |
| rfWrData | output | LANES*ELEM_W | Result data, one word per lane |
| rfWrEn | output | LANES | Per-lane write enable |

## Verification
Acceptance shows up in `busy` right after the accepting edge. The write address and lane enables for group g are valid while the clock is low in the (g+1)-th cycle after acceptance. The completion pulse appears just after the n-th edge. The bench samples one time unit after each rising edge. Each cycle it compares the slot and the number of enabled lanes with values computed from the clamped count. It counts edges until `done` and expects exactly n. The register contents are compared with a bench model only after completion, when every write of the instruction has landed.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  typedef struct packed {
    logic       active;
    logic       opLegal;
    logic [2:0] op;
  } seqStrobe_t;
endpackage

// File: rtl/vlu_ctrl.sv
module vlu_ctrl
  import vlu_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int MAX_VL = 128,
  parameter int REG_W  = 5,
  parameter int VL_W   = 8,
  parameter int SLOT_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [2:0]        issueOp,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [VL_W-1:0]   issueLen,
  output logic              issueReady,
  output logic              busy,
  output logic              done,
  output logic [SLOT_W-1:0] slot,
  output logic [REG_W-1:0]  srcA,
  output logic [REG_W-1:0]  srcB,
  output logic [REG_W-1:0]  dst,
  output logic [CNT_W-1:0]  validCount,
  output seqStrobe_t        strobe
);
  localparam int LANE_SH = $clog2(LANES);

  logic              busyQ, doneQ;
  logic [SLOT_W-1:0] slotQ;
  logic [VL_W-1:0]   vlQ;
  logic [2:0]        opQ;
  logic [REG_W-1:0]  srcAQ, srcBQ, dstQ;
  logic [VL_W:0]     remaining;
  logic [VL_W-1:0]   lenClamp;
  logic              lastGroup, accept;

  assign accept    = issueValid && !busyQ;
  assign lenClamp  = (issueLen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : issueLen;
  assign remaining = {1'b0, vlQ} - ((VL_W+1)'(slotQ) << LANE_SH);
  assign lastGroup = remaining <= (VL_W+1)'(LANES);
  assign validCount = lastGroup ? CNT_W'(remaining) : CNT_W'(LANES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      slotQ <= '0;
      vlQ   <= '0;
      opQ   <= '0;
      srcAQ <= '0;
      srcBQ <= '0;
      dstQ  <= '0;
    end else begin
      doneQ <= busyQ && lastGroup;
      if (accept) begin
        busyQ <= 1'b1;
        slotQ <= '0;
        vlQ   <= lenClamp;
        opQ   <= issueOp;
        srcAQ <= issueSrcA;
        srcBQ <= issueSrcB;
        dstQ  <= issueDst;
      end else if (busyQ) begin
        if (lastGroup) busyQ <= 1'b0;
        else           slotQ <= slotQ + 1'b1;
      end
    end
  end

  assign issueReady     = !busyQ;
  assign busy           = busyQ;
  assign done           = doneQ;
  assign slot           = slotQ;
  assign srcA           = srcAQ;
  assign srcB           = srcBQ;
  assign dst            = dstQ;
  assign strobe.active  = busyQ;
  assign strobe.op      = opQ;
  assign strobe.opLegal = opQ <= OP_XOR;

  p_slot_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastGroup) |=> (busyQ && slotQ == $past(slotQ) + 1'b1));
  p_first_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> slotQ == '0);
  p_done_after_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (!busyQ && $past(busyQ)));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> vlQ <= VL_W'(MAX_VL));
endmodule

// File: rtl/vlu_datapath.sv
module vlu_datapath
  import vlu_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 64,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              strobe,
  input  logic [CNT_W-1:0]        validCount,
  input  logic [LANES*ELEM_W-1:0] rdDataA,
  input  logic [LANES*ELEM_W-1:0] rdDataB,
  output logic [LANES*ELEM_W-1:0] wrData,
  output logic [LANES-1:0]        wrEn
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ELEM_W-1:0] opA, opB, res;
    assign opA = rdDataA[l*ELEM_W +: ELEM_W];
    assign opB = rdDataB[l*ELEM_W +: ELEM_W];
    always_comb begin
      case (strobe.op)
        OP_ADD:  res = opA + opB;
        OP_SUB:  res = opA - opB;
        OP_AND:  res = opA & opB;
        OP_OR:   res = opA | opB;
        OP_XOR:  res = opA ^ opB;
        default: res = '0;
      endcase
    end
    assign wrData[l*ELEM_W +: ELEM_W] = res;
    assign wrEn[l] = strobe.active && strobe.opLegal && (CNT_W'(l) < validCount);
  end

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |-> wrEn == '0);
  p_prefix_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn & (wrEn + LANES'(1))) == '0);
  p_illegal_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && strobe.op > OP_XOR) |-> wrEn == '0);
endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
  import vlu_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int ELEM_W   = 64,
  parameter int MAX_VL   = 128,
  parameter int NUM_REGS = 32,
  localparam int GROUPS  = MAX_VL / LANES,
  localparam int SLOT_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int VL_W    = $clog2(MAX_VL + 1),
  localparam int ADDR_W  = REG_W + SLOT_W,
  localparam int CNT_W   = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    issueValid,
  output logic                    issueReady,
  input  logic [2:0]              issueOp,
  input  logic [REG_W-1:0]        issueSrcA,
  input  logic [REG_W-1:0]        issueSrcB,
  input  logic [REG_W-1:0]        issueDst,
  input  logic [VL_W-1:0]         issueLen,
  output logic                    busy,
  output logic                    done,
  output logic [ADDR_W-1:0]       rfRdAddrA,
  input  logic [LANES*ELEM_W-1:0] rfRdDataA,
  output logic [ADDR_W-1:0]       rfRdAddrB,
  input  logic [LANES*ELEM_W-1:0] rfRdDataB,
  output logic [ADDR_W-1:0]       rfWrAddr,
  output logic [LANES*ELEM_W-1:0] rfWrData,
  output logic [LANES-1:0]        rfWrEn
);
  seqStrobe_t        strobe;
  logic [SLOT_W-1:0] slot;
  logic [REG_W-1:0]  srcA, srcB, dst;
  logic [CNT_W-1:0]  validCount;

  vlu_ctrl #(
    .LANES(LANES), .MAX_VL(MAX_VL), .REG_W(REG_W),
    .VL_W(VL_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueOp(issueOp),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueDst(issueDst), .issueLen(issueLen),
    .issueReady(issueReady), .busy(busy), .done(done),
    .slot(slot), .srcA(srcA), .srcB(srcB), .dst(dst),
    .validCount(validCount), .strobe(strobe)
  );

  vlu_datapath #(
    .LANES(LANES), .ELEM_W(ELEM_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .validCount(validCount),
    .rdDataA(rfRdDataA), .rdDataB(rfRdDataB),
    .wrData(rfWrData), .wrEn(rfWrEn)
  );

  assign rfRdAddrA = {srcA, slot};
  assign rfRdAddrB = {srcB, slot};
  assign rfWrAddr  = {dst, slot};

  p_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady) |=> busy);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |-> !issueReady);
endmodule

// File: tb/vec_lane_unit_tb.sv
module vec_lane_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES    = 8;
  localparam int ELEM_W   = 64;
  localparam int MAX_VL   = 128;
  localparam int NUM_REGS = 32;
  localparam int SLOT_W   = $clog2(MAX_VL / LANES);
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int VL_W     = $clog2(MAX_VL + 1);
  localparam int ADDR_W   = REG_W + SLOT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic issueReady;
  logic [2:0] issueOp = '0;
  logic [REG_W-1:0] issueSrcA = '0, issueSrcB = '0, issueDst = '0;
  logic [VL_W-1:0] issueLen = '0;
  logic busy, done;
  logic [ADDR_W-1:0] rfRdAddrA, rfRdAddrB, rfWrAddr;
  logic [LANES*ELEM_W-1:0] rfRdDataA, rfRdDataB, rfWrData;
  logic [LANES-1:0] rfWrEn;

  logic [ELEM_W-1:0] rfMem  [NUM_REGS][MAX_VL];
  logic [ELEM_W-1:0] expMem [NUM_REGS][MAX_VL];

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_lane_unit dut_i (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueReady(issueReady),
    .issueOp(issueOp), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueDst(issueDst), .issueLen(issueLen),
    .busy(busy), .done(done),
    .rfRdAddrA(rfRdAddrA), .rfRdDataA(rfRdDataA),
    .rfRdAddrB(rfRdAddrB), .rfRdDataB(rfRdDataB),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData), .rfWrEn(rfWrEn)
  );

  // register-file slice model: element i in lane i%LANES, slot i/LANES (R3)
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rfRdDataA[l*ELEM_W +: ELEM_W] =
        rfMem[int'(rfRdAddrA[ADDR_W-1:SLOT_W])][int'(rfRdAddrA[SLOT_W-1:0])*LANES + l];
      rfRdDataB[l*ELEM_W +: ELEM_W] =
        rfMem[int'(rfRdAddrB[ADDR_W-1:SLOT_W])][int'(rfRdAddrB[SLOT_W-1:0])*LANES + l];
    end
  end

  always @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (rfWrEn[l])
        rfMem[int'(rfWrAddr[ADDR_W-1:SLOT_W])][int'(rfWrAddr[SLOT_W-1:0])*LANES + l]
          <= rfWrData[l*ELEM_W +: ELEM_W];
  end

  function automatic logic [ELEM_W-1:0] refOp(input logic [2:0] op,
                                               input logic [ELEM_W-1:0] a, b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic compareMem(input string req);
    int bad = 0;
    logic [63:0] a = '0, e = '0;
    for (int r = 0; r < NUM_REGS; r++)
      for (int i = 0; i < MAX_VL; i++)
        if (rfMem[r][i] !== expMem[r][i] && bad == 0) begin
          bad = 1; a = rfMem[r][i]; e = expMem[r][i];
          $display("  first mismatch reg %0d element %0d", r, i);
        end
    check(bad == 0, req, a, e);
  endtask

  task automatic runInstr(input logic [2:0] op, input int a, input int b,
                          input int d, input int len, input bit interfere,
                          input string req);
    int vlc, n, cnt, g, want;
    bit orderOk, readyOk;
    vlc = (len > MAX_VL) ? MAX_VL : len;
    n = (vlc == 0) ? 1 : (vlc + LANES - 1) / LANES;
    if (op <= 3'd4)
      for (int i = 0; i < vlc; i++)
        expMem[d][i] = refOp(op, rfMem[a][i], rfMem[b][i]);
    @(negedge clk);
    issueValid = 1'b1; issueOp = op;
    issueSrcA = REG_W'(a); issueSrcB = REG_W'(b); issueDst = REG_W'(d);
    issueLen = VL_W'(len);
    @(posedge clk); #1;
    check(busy == 1'b1 && issueReady == 1'b0, "R2", {62'd0, busy, issueReady}, 64'd2);
    if (interfere) begin
      issueOp = 3'd0; issueDst = REG_W'(d ^ 1); issueLen = VL_W'(MAX_VL);
    end else issueValid = 1'b0;
    cnt = 0; g = 0; orderOk = 1; readyOk = 1;
    while (1) begin
      want = (op > 3'd4) ? 0 : ((vlc - g*LANES) >= LANES ? LANES : vlc - g*LANES);
      if (!busy || int'(rfWrAddr[SLOT_W-1:0]) != g || $countones(rfWrEn) != want
          || (rfWrEn & (rfWrEn + 1'b1)) != '0) orderOk = 0;
      if (issueReady) readyOk = 0;
      @(posedge clk); #1;
      cnt++; g++;
      if (done || cnt > MAX_VL + 4) break;
    end
    issueValid = 1'b0;
    check(orderOk, "R5/R6 slot order and lane enables", {63'd0, orderOk}, 64'd1);
    check(readyOk, "R8 ready low while busy", {63'd0, readyOk}, 64'd1);
    check(cnt == n && !busy, "R9 completion latency", 64'(cnt), 64'(n));
    @(posedge clk); #1;
    check(done == 1'b0, "R9 single done pulse", {63'd0, done}, 64'd0);
    compareMem(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NUM_REGS; r++)
      for (int i = 0; i < MAX_VL; i++) begin
        rfMem[r][i] = {$urandom(), $urandom()};
        expMem[r][i] = rfMem[r][i];
      end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset state
    check(busy == 0 && done == 0 && rfWrEn == '0 && issueReady == 1,
          "R1 reset state", {60'd0, busy, done, |rfWrEn, issueReady}, 64'd1);
    runInstr(3'd0, 1, 2, 3, 8, 0, "R4 add one group");
    runInstr(3'd1, 4, 5, 6, 13, 0, "R6 sub tail mask");
    runInstr(3'd4, 7, 8, 9, 128, 0, "R3 xor full length");
    runInstr(3'd2, 10, 11, 12, 200, 0, "R7 and clamp");
    runInstr(3'd3, 13, 14, 15, 0, 0, "R7 zero length");
    runInstr(3'd6, 16, 17, 18, 40, 0, "R10 illegal op");
    runInstr(3'd0, 19, 19, 19, 77, 0, "R4 alias dst=src");
    runInstr(3'd1, 20, 21, 22, 33, 1, "R8 issue during busy ignored");
    runInstr(3'd0, 23, 24, 25, 1, 0, "R6 single element");
    for (int t = 0; t < 40; t++) begin
      int lenR;
      lenR = ($urandom_range(0, 9) == 0) ? int'($urandom_range(129, 255))
                                         : int'($urandom_range(0, 128));
      runInstr(3'($urandom_range(0, 7)), int'($urandom_range(0, 31)),
               int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
               lenR, bit'($urandom_range(0, 1)), "R4 random instruction");
    end
    #1;
    check(busy == 0 && rfWrEn == '0, "R1 idle quiet", {62'd0, busy, |rfWrEn}, 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule